// File: doc/BRIEF.md
# Stub Vector Serial Readout

This block is a test path that moves a wide vector of stub flags, one flag per strip pair, off the chip through a single pin. On each bunch-crossing clock edge the block looks at the vector. If any flag is set and no transfer is running, it captures the whole vector into a parallel-load shift register. It then sends the vector out one bit per crossing.

Each transfer is framed on the pin. First comes a start bit of 1, then the data bits from the lowest strip upward. The line rests at 0 between transfers. A second register, shifting in step with the data register, holds a single marker bit. This marker tells the block when the last data bit has left, and so drives the busy output.

A vector that arrives while a transfer is running is discarded, and a saturating counter records each such loss. A configuration enable bit switches the whole path off. Turning it off clears both registers and forces the pin low.

Top module: `stub_serial_readout`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ser_out` and `busy` are 0 and `drop_count` is 0.
- R2: A transfer starts only at an edge where `enable` is 1, `busy` is 0 and at least one bit of `stub_vec` is 1. An all-zero vector leaves `busy` and `ser_out` at 0.
- R3: In the cycle after a starting edge, `ser_out` is 1 (the start bit). In the following 127 cycles it carries `stub_vec[0]`, `stub_vec[1]`, up to `stub_vec[126]` as captured at the starting edge.
- R4: `busy` is 1 for exactly 128 cycles after a starting edge and then 0. `ser_out` is 0 in every cycle where `busy` is 0.
- R5: At an edge where `enable` and `busy` are both 1 and `stub_vec` is non-zero, the vector is not captured. The frame being sent is unchanged and `drop_count` rises by one.
- R6: `drop_count` is 8 bits wide and holds at 255 rather than wrapping.
- R7: At an edge where `enable` is 0, both registers clear. From the next cycle `ser_out` and `busy` are 0. While `enable` stays 0, vectors are neither captured nor counted, and `drop_count` keeps its value.
- R8: A vector present at the first edge where `busy` is 0 again starts a new frame. Frames sent back to back are therefore separated by exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Path enable from configuration; 0 inhibits and clears |
| stub_vec | input | 127 | Stub flags, bit 0 is the lowest strip |
| ser_out | output | 1 | Serial line: start bit, then data, lowest strip first |
| busy | output | 1 | A frame is on the line |
| drop_count | output | 8 | Saturating count of vectors lost while busy |

## Verification
The bench targets the following corner cases:
- The edge where the marker reaches the output end. A design off by one there would shorten or lengthen frames, or would start the next frame with no idle gap.
- An all-zero vector presented while idle. A design that loaded it regardless of the OR flag would raise `busy` with a silent frame.
- Loss counting. The counter is driven past 255, and vectors are presented while disabled, to catch a wrapping counter or a counter that counts when it should not.
- Disabling mid-frame. A path that only stopped shifting, instead of clearing, would leave a stale bit on the line or stay busy.

// File: rtl/stub_ro_pkg.sv
package stub_ro_pkg;
  localparam int unsigned STUB_BITS_DEF = 127;
  localparam int unsigned DROP_W_DEF    = 8;

  // Operation applied to both shift registers in a cycle
  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_LOAD  = 2'd1,
    SR_SHIFT = 2'd2,
    SR_CLEAR = 2'd3
  } sr_op_e;
endpackage

// File: rtl/stub_ro_data_sr.sv
module stub_ro_data_sr
  import stub_ro_pkg::*;
#(
  parameter int unsigned NB = STUB_BITS_DEF
) (
  input  logic          clk,
  input  sr_op_e        op,
  input  logic [NB-1:0] vec,
  output logic          line
);
  localparam int unsigned FW = NB + 1;

  logic [FW-1:0] frame_q;

  always_ff @(posedge clk) begin
    unique case (op)
      SR_LOAD:  frame_q <= {vec, 1'b1};
      SR_SHIFT: frame_q <= {1'b0, frame_q[FW-1:1]};
      SR_CLEAR: frame_q <= '0;
      default:  frame_q <= frame_q;
    endcase
  end

  assign line = frame_q[0];
endmodule

// File: rtl/stub_ro_shadow_sr.sv
module stub_ro_shadow_sr
  import stub_ro_pkg::*;
#(
  parameter int unsigned NB = STUB_BITS_DEF
) (
  input  logic   clk,
  input  sr_op_e op,
  output logic   active
);
  localparam int unsigned FW = NB + 1;

  logic [FW-1:0] mark_q;

  always_ff @(posedge clk) begin
    unique case (op)
      SR_LOAD:  mark_q <= {1'b1, {(FW-1){1'b0}}};
      SR_SHIFT: mark_q <= {1'b0, mark_q[FW-1:1]};
      SR_CLEAR: mark_q <= '0;
      default:  mark_q <= mark_q;
    endcase
  end

  assign active = |mark_q;
endmodule

// File: rtl/stub_ro_drop_ctr.sv
module stub_ro_drop_ctr #(
  parameter int unsigned DW = stub_ro_pkg::DROP_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [DW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && (count != {DW{1'b1}}))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/stub_serial_readout.sv
module stub_serial_readout
  import stub_ro_pkg::*;
#(
  parameter int unsigned NB = STUB_BITS_DEF,
  parameter int unsigned DW = DROP_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [NB-1:0] stub_vec,
  output logic          ser_out,
  output logic          busy,
  output logic [DW-1:0] drop_count
);
  logic   any_stub;
  logic   drop_inc;
  sr_op_e op;

  assign any_stub = |stub_vec;

  always_comb begin
    if (rst || !enable)
      op = SR_CLEAR;
    else if (busy)
      op = SR_SHIFT;
    else if (any_stub)
      op = SR_LOAD;
    else
      op = SR_HOLD;
  end

  assign drop_inc = enable && busy && any_stub;

  stub_ro_data_sr #(.NB(NB)) u_data (
    .clk  (clk),
    .op   (op),
    .vec  (stub_vec),
    .line (ser_out)
  );

  stub_ro_shadow_sr #(.NB(NB)) u_shadow (
    .clk    (clk),
    .op     (op),
    .active (busy)
  );

  stub_ro_drop_ctr #(.DW(DW)) u_drop (
    .clk   (clk),
    .rst   (rst),
    .inc   (drop_inc),
    .count (drop_count)
  );
endmodule

// File: rtl/stub_serial_readout_chk.sv
module stub_serial_readout_chk #(
  parameter int unsigned NB = stub_ro_pkg::STUB_BITS_DEF,
  parameter int unsigned DW = stub_ro_pkg::DROP_W_DEF
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [NB-1:0] stub_vec,
  input logic          ser_out,
  input logic          busy,
  input logic [DW-1:0] drop_count
);
  localparam int unsigned RW = $clog2(NB + 3) + 1;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)
      run_len <= '0;
    else if (busy)
      run_len <= run_len + 1'b1;
    else
      run_len <= '0;
  end

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && !busy && (|stub_vec)) |=> (busy && ser_out));

  assert_no_empty_load_R2: assert property (@(posedge clk) disable iff (rst)
    (enable && !busy && !(|stub_vec)) |=> (!busy && !ser_out));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_out);

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    run_len <= RW'(NB + 1));

  assert_drop_inc_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && busy && (|stub_vec) && (drop_count != {DW{1'b1}}))
      |=> (drop_count == $past(drop_count) + 1'b1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (drop_count == {DW{1'b1}}) |=> (drop_count == {DW{1'b1}}));

  assert_disable_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !ser_out));

  assert_disable_hold_cnt_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(drop_count));
endmodule

bind stub_serial_readout stub_serial_readout_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .stub_vec   (stub_vec),
  .ser_out    (ser_out),
  .busy       (busy),
  .drop_count (drop_count)
);

// File: tb/sim_stub_serial_readout.sv
module sim_stub_serial_readout;
  localparam int NB = 127;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [NB-1:0] stub_vec = '0;
  logic          ser_out;
  logic          busy;
  logic [DW-1:0] drop_count;

  int checks = 0;
  int errors = 0;

  // reference state, written from the requirements
  int          m_left = 0;
  logic [NB:0] m_frame = '0;
  int          m_drop = 0;

  always #10 clk = ~clk;

  stub_serial_readout #(.NB(NB), .DW(DW)) u0 (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .stub_vec   (stub_vec),
    .ser_out    (ser_out),
    .busy       (busy),
    .drop_count (drop_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] rand_vec();
    logic [127:0] w;
    int mode = $urandom % 4;
    w = {$urandom, $urandom, $urandom, $urandom};
    if (mode == 1) return NB'(1) << ($urandom % NB);
    if (mode == 2) return w[NB-1:0];
    return '0;
  endfunction

  task automatic model_edge(input logic r, input logic en, input logic [NB-1:0] v);
    if (r) begin
      m_left = 0; m_frame = '0; m_drop = 0;
    end else if (!en) begin
      m_left = 0; m_frame = '0;
    end else if (m_left == 0) begin
      if (|v) begin
        m_left = NB + 1;
        m_frame = {v, 1'b1};
      end
    end else begin
      if ((|v) && m_drop < 255) m_drop++;
      m_frame = m_frame >> 1;
      m_left--;
    end
  endtask

  // drive at negedge, update reference at posedge, compare just after it
  task automatic step(input logic r, input logic en, input logic [NB-1:0] v);
    @(negedge clk);
    rst = r; enable = en; stub_vec = v;
    @(posedge clk);
    model_edge(r, en, v);
    #1;
    chk("R3", "ser_out", int'(ser_out), int'(m_frame[0]));
    chk("R4", "busy", int'(busy), int'(m_left != 0));
    chk("R5", "drop_count", int'(drop_count), m_drop);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NB-1:0] pat;
    logic [DW-1:0] held;
    void'($urandom(32'd20240611));

    // R1: reset
    step(1'b1, 1'b1, '1);
    step(1'b1, 1'b1, '1);
    chk("R1", "ser_out in reset", int'(ser_out), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "drop_count in reset", int'(drop_count), 0);

    // R2: all-zero vector does not start a frame
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);
    chk("R2", "busy after zero vectors", int'(busy), 0);
    chk("R2", "ser_out after zero vectors", int'(ser_out), 0);

    // R3/R4: one frame with a known pattern, bit order checked
    pat = '0;
    for (int i = 0; i < NB; i += 3) pat[i] = 1'b1;
    pat[NB-1] = 1'b1;
    step(1'b0, 1'b1, pat);
    chk("R3", "start bit", int'(ser_out), 1);
    for (int i = 0; i < NB; i++) begin
      step(1'b0, 1'b1, '0);
      chk("R3", $sformatf("data bit %0d", i), int'(ser_out), int'(pat[i]));
      chk("R4", "busy during frame", int'(busy), 1);
    end
    step(1'b0, 1'b1, '0);
    chk("R4", "busy after 128 cycles", int'(busy), 0);
    chk("R4", "line idle after frame", int'(ser_out), 0);

    // R5: vectors during a frame are dropped and counted
    step(1'b0, 1'b1, NB'(1));
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '1);
    chk("R5", "drops counted", int'(drop_count), 10);
    for (int i = 0; i < 117; i++) step(1'b0, 1'b1, '0);
    chk("R5", "frame still busy at last bit", int'(busy), 1);
    step(1'b0, 1'b1, '0);

    // R8: back-to-back frames with one idle gap
    step(1'b0, 1'b1, NB'(2));
    for (int i = 0; i < NB; i++) step(1'b0, 1'b1, NB'(4));
    step(1'b0, 1'b1, NB'(4));
    chk("R8", "idle gap busy", int'(busy), 0);
    step(1'b0, 1'b1, NB'(4));
    chk("R8", "next frame busy", int'(busy), 1);
    chk("R8", "next frame start bit", int'(ser_out), 1);
    step(1'b0, 1'b1, '0);
    chk("R8", "next frame data bit 0", int'(ser_out), 0);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    chk("R8", "next frame data bit 2", int'(ser_out), 1);

    // R7: disable mid-frame clears, ignores and keeps count
    held = drop_count;
    step(1'b0, 1'b0, '1);
    chk("R7", "busy after disable", int'(busy), 0);
    chk("R7", "ser_out after disable", int'(ser_out), 0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, rand_vec() | NB'(1));
    chk("R7", "count held while disabled", int'(drop_count), int'(held));
    chk("R7", "still idle while disabled", int'(busy), 0);
    step(1'b0, 1'b1, '0);
    chk("R7", "idle after re-enable with zero", int'(busy), 0);

    // R6: saturation
    for (int i = 0; i < 600; i++) step(1'b0, 1'b1, '1);
    chk("R6", "saturated count", int'(drop_count), 255);

    // random mix after a fresh reset
    step(1'b1, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    chk("R1", "count after second reset", int'(drop_count), 0);
    for (int i = 0; i < 4000; i++)
      step(1'b0, ($urandom % 40) != 0, rand_vec());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule